// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a synchronous host read and write a 32-bit asynchronous static RAM with an 18-bit address. The RAM is split into four 8-bit lanes, and each lane has its own active-low select. The host raises a one-cycle request that carries the address, the write data, a byte mask and a direction flag. The controller then sequences the memory's address, lane selects, write strobe and output enable. It also sequences its own tri-state data drive. At the end it returns a one-cycle completion pulse and, for reads, the registered word.

Every memory phase is a whole number of clock cycles. The strobe and access times are given in nanoseconds together with the clock period, and the cycle counts are rounded up from them. A write always holds output enable high, so the strobe only has to meet its own minimum width. It does not have to cover the memory's output turn-off time as well. When a write follows a read, a turnaround cycle keeps the data drivers off the bus while the memory releases it.

Once after reset the controller samples four density strap pins. It reports whether they show the one supported depth.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, all lane selects, the write strobe and output enable are high (inactive), the data drive enable is low, `done` is low, and both density flags are low.
- R2: A read drives all four lane selects low and output enable low, with the write strobe high, for RD_CYC = ceil(RD_NS/CLK_NS) cycles (2 by default). At the end of the last of these cycles the read data is captured. `done` is high for exactly one cycle, RD_CYC clock edges after the edge that accepted the request. `rd_data` holds its value until the next read completes.
- R3: A write keeps output enable high throughout. It holds the write strobe low for WP_CYC cycles and enables the data drive during exactly those cycles plus the one cycle before them. `done` rises SETUP_CYC+WP_CYC+REC_CYC edges after the accepting edge (4 by default).
- R4: Byte-mask bit i selects lane i, which is `mem_cs_n[i]` and data bits [8i+7:8i]. A lane whose mask bit is 0 keeps its select high during the write, and that byte keeps its previous contents. A mask of 0 writes nothing.
- R5: `mem_addr` changes only on an edge after a cycle in which the write strobe and all four lane selects were high.
- R6: The write strobe stays low for at least WP_CYC = ceil(WP_NS/CLK_NS) cycles. With the defaults this is 2 cycles of 10 ns, which covers the 12 ns minimum.
- R7: The data drive is never enabled while output enable is low. A write that directly follows a read gets TURN_CYC extra cycles of latency. Output enable has been high for at least TURN_CYC+1 full cycles before the data drive is enabled.
- R8: A request raised while a transfer is in progress is ignored. It produces no memory cycle and no `done` pulse.
- R9: The density pins are sampled once, on the first clock edge after reset. The pattern `pd == 4'b1100` (pd[1:0] low, pd[3:2] high) sets `dens_256k` and clears `dens_bad`. Any other pattern sets `dens_bad` and clears `dens_256k`. Later changes on the pins have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte mask, bit i for lane i |
| rd_data | output | 32 | Last read word |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 4 | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 32 | Data to memory |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_i | input | 32 | Data from memory |
| pd | input | 4 | Density strap pins |
| dens_256k | output | 1 | Straps show the supported depth |
| dens_bad | output | 1 | Straps show an unsupported depth |

## Verification
The bench attaches a behavioural memory that commits a write when the strobe rises. That memory fails the run if the address moves while the strobe is low, or if the strobe is shorter than its minimum width. A controller with a wrong lane mapping or a leaky mask therefore reads back corrupted bytes. The tightest read-then-write turnaround is issued back to back. Without the turnaround cycle, a controller would enable its drivers only one cycle after output enable rose and would miss the required gap and latency. Further checks cover a request injected mid-transfer, which a careless design would start as a second cycle with a second pulse, and strap pins changed after the sample or presented with an unsupported pattern.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW        = 18,
  parameter int DW        = 32,
  parameter int CLK_NS    = 10,
  parameter int WP_NS     = 12,
  parameter int RD_NS     = 15,
  parameter int SETUP_CYC = 1,
  parameter int REC_CYC   = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic [DW-1:0]   rd_data,
  output logic            done,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_cs_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_i,
  input  logic [3:0]      pd,
  output logic            dens_256k,
  output logic            dens_bad
);
  localparam int LANES  = DW / 8;
  localparam int WP_CYC = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int CMAX   = SETUP_CYC + WP_CYC + REC_CYC + RD_CYC + TURN_CYC;
  localparam int CW     = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_WPUL, S_RECV, S_READ} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [LANES-1:0] be_q;
  logic            last_rd;
  logic            sampled;

  wire cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      be_q      <= '0;
      last_rd   <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_cs_n  <= '1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= req_addr;
          if (req_write) begin
            mem_dq_o <= req_wdata;
            be_q     <= req_be;
            if (last_rd && TURN_CYC > 0) begin
              st  <= S_TURN;
              cnt <= CW'(TURN_CYC > 0 ? TURN_CYC - 1 : 0);
            end else begin
              st        <= S_SETUP;
              cnt       <= CW'(SETUP_CYC - 1);
              mem_cs_n  <= ~req_be;
              mem_dq_oe <= (SETUP_CYC == 1);
            end
          end else begin
            st       <= S_READ;
            cnt      <= CW'(RD_CYC - 1);
            mem_cs_n <= '0;
            mem_oe_n <= 1'b0;
          end
        end
        S_TURN: if (cnt_zero) begin
          st        <= S_SETUP;
          cnt       <= CW'(SETUP_CYC - 1);
          mem_cs_n  <= ~be_q;
          mem_dq_oe <= (SETUP_CYC == 1);
        end else cnt <= cnt - 1'b1;
        S_SETUP: if (cnt_zero) begin
          st        <= S_WPUL;
          cnt       <= CW'(WP_CYC - 1);
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
        end else begin
          cnt       <= cnt - 1'b1;
          mem_dq_oe <= (cnt == CW'(1));
        end
        S_WPUL: if (cnt_zero) begin
          st        <= S_RECV;
          cnt       <= CW'(REC_CYC - 1);
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          mem_cs_n  <= '1;
        end else cnt <= cnt - 1'b1;
        S_RECV: if (cnt_zero) begin
          st      <= S_IDLE;
          done    <= 1'b1;
          last_rd <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_READ: if (cnt_zero) begin
          st       <= S_IDLE;
          rd_data  <= mem_dq_i;
          mem_cs_n <= '1;
          mem_oe_n <= 1'b1;
          done     <= 1'b1;
          last_rd  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled   <= 1'b0;
      dens_256k <= 1'b0;
      dens_bad  <= 1'b0;
    end else if (!sampled) begin
      sampled   <= 1'b1;
      dens_256k <= (pd == 4'b1100);
      dens_bad  <= (pd != 4'b1100);
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW     = 18,
  parameter int LANES  = 4,
  parameter int CLK_NS = 10,
  parameter int WP_NS  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    mem_addr,
  input logic [LANES-1:0] mem_cs_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic             mem_dq_oe,
  input logic             done
);
  localparam int WP_CYC = (WP_NS + CLK_NS - 1) / CLK_NS;

  logic [7:0] wl_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wl_cnt <= '0;
    else if (!mem_we_n) wl_cnt <= (wl_cnt == 8'hFF) ? wl_cnt : wl_cnt + 8'd1;
    else wl_cnt <= '0;
  end

  // R3
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  // R3
  we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  // R7
  oe_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R2
  read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_cs_n == '0 && mem_we_n));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> ($past(mem_we_n) && $past(mem_cs_n) == '1));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_cnt >= 8'(WP_CYC)));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .done(done)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WPC = 2, RDC = 2, SUC = 1, RCC = 1, TNC = 1;
  localparam int NV = 12;

  // {write, addr, mask, wdata, expected read}
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 8'h01, 4'hF, 32'h11223344, 32'h0},
    {1'b0, 8'h01, 4'h0, 32'h0,        32'h11223344},
    {1'b1, 8'h02, 4'hF, 32'hA5A5A5A5, 32'h0},
    {1'b1, 8'h01, 4'h1, 32'h000000EE, 32'h0},
    {1'b0, 8'h01, 4'h0, 32'h0,        32'h112233EE},
    {1'b1, 8'h01, 4'hA, 32'hBB00CC00, 32'h0},
    {1'b0, 8'h01, 4'h0, 32'h0,        32'hBB22CCEE},
    {1'b0, 8'h02, 4'h0, 32'h0,        32'hA5A5A5A5},
    {1'b1, 8'h02, 4'h0, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h02, 4'h0, 32'h0,        32'hA5A5A5A5},
    {1'b1, 8'h03, 4'h6, 32'h12345678, 32'h0},
    {1'b0, 8'h03, 4'h0, 32'h0,        32'h00345600}
  };

  logic clk = 0, rst_n = 0, req = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0, pd = 4'b1100;
  logic [31:0] rd_data, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic done, mem_we_n, mem_oe_n, mem_dq_oe, dens_256k, dens_bad;

  int nchk = 0, nerr = 0;
  logic [31:0] mdl [256] = '{default: 32'h0};

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rd_data(rd_data), .done(done),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .pd(pd),
    .dens_256k(dens_256k), .dens_bad(dens_bad));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: reads combinational, writes commit when the strobe rises
  always_comb begin
    mem_dq_i = '0;
    for (int l = 0; l < 4; l++)
      if (!mem_cs_n[l] && !mem_oe_n && mem_we_n)
        mem_dq_i[8*l +: 8] = mdl[mem_addr[7:0]][8*l +: 8];
  end

  int wl = 0, hi = 100;
  logic pdq = 0;
  logic [17:0] w_addr;
  logic [3:0]  w_lanes;
  logic [31:0] w_data;
  always @(negedge clk) begin
    if (!rst_n) begin
      wl = 0; hi = 100; pdq = 0;
    end else begin
      if (mem_dq_oe && !pdq) chk(hi >= TNC + 1, "R7 oe-high gap before drive", hi, TNC + 1);
      hi  = mem_oe_n ? (hi < 100 ? hi + 1 : hi) : 0;
      pdq = mem_dq_oe;
      if (!mem_we_n) begin
        if (wl == 0) w_addr = mem_addr;
        else chk(mem_addr == w_addr, "R5 address moved during strobe", 32'(mem_addr), 32'(w_addr));
        chk(mem_dq_oe && mem_oe_n, "R3 drive on / oe off while strobe low", {mem_dq_oe, mem_oe_n}, 2'b11);
        w_lanes = ~mem_cs_n;
        w_data  = mem_dq_o;
        wl++;
      end else if (wl != 0) begin
        chk(wl * CLK_PERIOD >= 12, "R6 strobe width ns", wl * CLK_PERIOD, 12);
        for (int l = 0; l < 4; l++)
          if (w_lanes[l]) mdl[w_addr[7:0]][8*l +: 8] = w_data[8*l +: 8];
        wl = 0;
      end
    end
  end

  task automatic do_op(input logic w, input logic [17:0] a, input logic [3:0] be,
                       input logic [31:0] d, output int lat, output logic [31:0] rd);
    req = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk); req = 0; lat = 1;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    rd = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] rd;
    bit prev_rd = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !done,
        "R1 reset outputs", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, done}, 8'b1111_1100);
    chk(!dens_256k && !dens_bad, "R1 density flags in reset", {dens_256k, dens_bad}, 0);
    rst_n = 1;
    @(negedge clk);
    // R9
    chk(dens_256k && !dens_bad, "R9 supported straps", {dens_256k, dens_bad}, 2'b10);
    pd = 4'b0000;
    repeat (2) @(negedge clk);
    chk(dens_256k && !dens_bad, "R9 straps ignored after sample", {dens_256k, dens_bad}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v = VEC[i];
      do_op(v[76], {10'd0, v[75:68]}, v[67:64], v[63:32], lat, rd);
      if (v[76]) begin
        // R3 R7
        chk(lat == (prev_rd ? 1 + TNC + SUC + WPC + RCC : 1 + SUC + WPC + RCC),
            prev_rd ? "R7 write-after-read latency" : "R3 write latency",
            lat, prev_rd ? 1 + TNC + SUC + WPC + RCC : 1 + SUC + WPC + RCC);
      end else begin
        chk(lat == 1 + RDC, "R2 read latency", lat, 1 + RDC);
        chk(rd == v[31:0], "R4 read data per lane", rd, v[31:0]);
      end
      prev_rd = !v[76];
    end

    // R8: request during a busy write is ignored
    req = 1; req_write = 1; req_addr = 18'd5; req_be = 4'hF; req_wdata = 32'hCAFEF00D;
    @(negedge clk); req = 0;
    @(negedge clk); req = 1; req_write = 0; req_addr = 18'd6;
    @(negedge clk); req = 0;
    lat = 0;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    begin
      int extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done || !mem_oe_n) extra++;
      end
      chk(extra == 0, "R8 no extra cycle or done after busy request", extra, 0);
    end
    do_op(0, 18'd5, 4'h0, 32'h0, lat, rd);
    chk(rd == 32'hCAFEF00D, "R8 write intact after ignored request", rd, 32'hCAFEF00D);
    do_op(1, 18'd7, 4'hF, 32'h01020304, lat, rd);
    chk(rd_data == 32'hCAFEF00D, "R2 read data held across write", rd_data, 32'hCAFEF00D);

    // R9: unsupported straps after a fresh reset
    rst_n = 0; pd = 4'b0100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!dens_256k && dens_bad, "R9 unsupported straps", {dens_256k, dens_bad}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule